// File: doc/BRIEF.md
# Serial link resynchronization controller

This controller brings a point-to-point asynchronous serial link back into step after one side hits an error. It sits beside a UART and its transfer engine. When a break arrives on the line, or local logic raises an error request, it takes the transmit pin away from the UART and drives the pin level itself. It then stops DMA, shuts the UART down, and flushes the FIFOs one step later, once the character already in the shifter has drained. After that it exchanges a simple low-then-high level handshake with the peer. When the handshake completes, it hands the pin back, turns the UART and FIFOs on again, and counts the event.

One side is configured as master and the other as responder. Every step of the sequence waits for a `tick` strobe. The surrounding logic produces that strobe every two character frames, and only while recovery is under way. A level on the receive line counts only if it held unchanged over one whole tick interval. An interval that ends with the first tick after recovery starts is never accepted, so data bits are never mistaken for handshake levels. After reset the controller sits in the handshake stage with the UART and FIFOs off, so the first link start-up uses the same exchange.

Top module: `link_resync_ctrl`

## Requirements
- R1: After reset: `pin_direct`=1, `tx_lvl`=0, `uart_en`=0, `fifo_en`=0, `dma_stop`=1, `sync_done`=0, `resync_cnt`=0. The controller is then waiting in the handshake stage for the peer's low level.
- R2: While running (`pin_direct`=0), a cycle with `brk_det` or `err_req` high gives, on the next cycle: `pin_direct`=1, `tx_lvl`=0, `dma_stop`=1, `uart_en`=0, with `fifo_en` still 1.
- R3: `fifo_en` drops only at the first `tick` after recovery starts, never earlier.
- R4: During recovery the controller moves at most one step per `tick`. With no tick, `pin_direct`, `tx_lvl` and `fifo_en` keep their values.
- R5: The receive level counts as held only when both hold: it did not change at any cycle since the previous tick, and at least one tick has passed since recovery began. A one-cycle glitch voids the interval.
- R6: The master drives `tx_lvl` high at the tick that ends an interval in which the peer's line was held low.
- R7: The master completes at the tick that ends an interval in which the peer's line was held high.
- R8: The responder first waits for the peer's held low level, keeping `tx_lvl` low. It then waits for a held high level and completes; before any held low is seen, a held high has no effect.
- R9: On completion, on the next cycle: `sync_done` is high for exactly one cycle, `pin_direct`=0, `tx_lvl`=1, `uart_en`=1, `fifo_en`=1, `dma_stop`=0. In the same cycle `resync_cnt` (width `CNT_W`, default 16) rises by one, saturating at its maximum.
- R10: `brk_det` and `err_req` are ignored during recovery, including the cycle of the completing tick. A request still high one cycle later starts a new recovery.
- R11: A `tick` while running has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Step strobe, one pulse per two character frames |
| is_master | input | 1 | 1 = master role, 0 = responder role |
| brk_det | input | 1 | Break detected on the receive line |
| err_req | input | 1 | Local request to resynchronize |
| rx_lvl | input | 1 | Sampled level of the peer's line |
| pin_direct | output | 1 | 1 = pin driven by this block, 0 = pin owned by UART |
| tx_lvl | output | 1 | Level driven on the pin in direct mode |
| uart_en | output | 1 | UART plus transmit and receive enable |
| fifo_en | output | 1 | FIFO enable (clearing it flushes the FIFOs) |
| dma_stop | output | 1 | Request to halt DMA transfers |
| sync_done | output | 1 | One-cycle pulse on completed resynchronization |
| resync_cnt | output | CNT_W | Saturating count of resynchronizations |

## Verification
The completing tick and a fresh break request can arrive in the same cycle. The bench raises `brk_det` together with the final handshake tick and keeps it high one cycle longer. It expects the completion to win: `sync_done` pulses, the pins return to the UART and the count rises. It then expects a new recovery to start on the following cycle. A second coincidence, a counter increment at saturation, is judged by checking that `sync_done` still pulses while `resync_cnt` stays at its maximum.

// File: rtl/link_resync_pkg.sv
package link_resync_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_HALT,
    ST_FLUSH,
    ST_PEER_LO,
    ST_MST_HI,
    ST_RSP_HI
  } rs_state_e;

  typedef struct packed {
    logic pin_direct;
    logic tx_lvl;
    logic uart_en;
    logic fifo_en;
    logic dma_stop;
  } pin_ctl_t;

  function automatic pin_ctl_t ctl_of(rs_state_e s);
    pin_ctl_t c;
    c = '{pin_direct: 1'b1, tx_lvl: 1'b0, uart_en: 1'b0, fifo_en: 1'b0, dma_stop: 1'b1};
    case (s)
      ST_RUN:    c = '{pin_direct: 1'b0, tx_lvl: 1'b1, uart_en: 1'b1, fifo_en: 1'b1, dma_stop: 1'b0};
      ST_HALT:   c.fifo_en = 1'b1;
      ST_MST_HI: c.tx_lvl = 1'b1;
      default:   c = c;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lr_level_mon.sv
module lr_level_mon (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic tick,
  input  logic rx_lvl,
  output logic held_lo,
  output logic held_hi
);
  logic rx_q;
  logic dirty;
  logic full;
  logic moved;
  logic clean;

  assign moved = rx_lvl != rx_q;
  assign clean = tick && full && !dirty && !moved;
  assign held_lo = clean && !rx_lvl;
  assign held_hi = clean && rx_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q  <= 1'b0;
      dirty <= 1'b0;
      full  <= 1'b0;
    end else begin
      rx_q <= rx_lvl;
      if (arm) begin
        dirty <= 1'b0;
        full  <= 1'b0;
      end else if (tick) begin
        dirty <= 1'b0;
        full  <= 1'b1;
      end else if (moved) begin
        dirty <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lr_seq_fsm.sv
module lr_seq_fsm
  import link_resync_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     is_master,
  input  logic     start,
  input  logic     held_lo,
  input  logic     held_hi,
  output pin_ctl_t ctl,
  output logic     done,
  output logic     sync_pulse,
  output logic     running
);
  rs_state_e state, nxt;

  assign running = state == ST_RUN;
  assign done = tick && held_hi && (state == ST_MST_HI || state == ST_RSP_HI);

  always_comb begin
    nxt = state;
    case (state)
      ST_RUN:     if (start) nxt = ST_HALT;
      ST_HALT:    if (tick) nxt = ST_FLUSH;
      ST_FLUSH:   if (tick) nxt = ST_PEER_LO;
      ST_PEER_LO: if (tick && held_lo) nxt = is_master ? ST_MST_HI : ST_RSP_HI;
      ST_MST_HI,
      ST_RSP_HI:  if (done) nxt = ST_RUN;
      default:    nxt = ST_PEER_LO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_PEER_LO;
      ctl        <= ctl_of(ST_PEER_LO);
      sync_pulse <= 1'b0;
    end else begin
      state      <= nxt;
      ctl        <= ctl_of(nxt);
      sync_pulse <= done;
    end
  end
endmodule

// File: rtl/lr_sat_cnt.sv
module lr_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/link_resync_ctrl.sv
module link_resync_ctrl
  import link_resync_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             is_master,
  input  logic             brk_det,
  input  logic             err_req,
  input  logic             rx_lvl,
  output logic             pin_direct,
  output logic             tx_lvl,
  output logic             uart_en,
  output logic             fifo_en,
  output logic             dma_stop,
  output logic             sync_done,
  output logic [CNT_W-1:0] resync_cnt
);
  pin_ctl_t ctl;
  logic held_lo, held_hi, done, running;

  lr_level_mon u_mon (
    .clk(clk), .rst(rst), .arm(running), .tick(tick), .rx_lvl(rx_lvl),
    .held_lo(held_lo), .held_hi(held_hi)
  );

  lr_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .tick(tick), .is_master(is_master),
    .start(brk_det | err_req), .held_lo(held_lo), .held_hi(held_hi),
    .ctl(ctl), .done(done), .sync_pulse(sync_done), .running(running)
  );

  lr_sat_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(done), .cnt(resync_cnt)
  );

  assign pin_direct = ctl.pin_direct;
  assign tx_lvl     = ctl.tx_lvl;
  assign uart_en    = ctl.uart_en;
  assign fifo_en    = ctl.fifo_en;
  assign dma_stop   = ctl.dma_stop;
endmodule

// File: rtl/link_resync_chk.sv
module link_resync_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             is_master,
  input logic             brk_det,
  input logic             err_req,
  input logic             pin_direct,
  input logic             tx_lvl,
  input logic             uart_en,
  input logic             fifo_en,
  input logic             dma_stop,
  input logic             sync_done,
  input logic [CNT_W-1:0] resync_cnt
);
  // R2
  enter_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (!pin_direct && (brk_det || err_req)) |=> (pin_direct && dma_stop && !uart_en && fifo_en && !tx_lvl));

  // R3
  flush_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fifo_en) |-> ($past(tick) && $past(pin_direct)));

  // R4
  step_per_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pin_direct) && !$past(tick) && pin_direct) |-> ($stable(tx_lvl) && $stable(fifo_en)));

  // R6
  master_high_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_lvl) && pin_direct) |-> ($past(tick) && $past(is_master)));

  // R9
  done_state_chk: assert property (@(posedge clk) disable iff (rst)
    sync_done |-> (uart_en && fifo_en && !pin_direct && !dma_stop && tx_lvl));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sync_done |=> !sync_done);

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (resync_cnt != $past(resync_cnt)) |-> (sync_done && (resync_cnt - $past(resync_cnt)) == CNT_W'(1)));

  // R11
  run_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!pin_direct && tick && !brk_det && !err_req) |=> !pin_direct);
endmodule

bind link_resync_ctrl link_resync_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .is_master(is_master),
  .brk_det(brk_det), .err_req(err_req), .pin_direct(pin_direct),
  .tx_lvl(tx_lvl), .uart_en(uart_en), .fifo_en(fifo_en),
  .dma_stop(dma_stop), .sync_done(sync_done), .resync_cnt(resync_cnt)
);

// File: tb/link_resync_ctrl_test.sv
module link_resync_ctrl_test;
  localparam int CLK_P = 10;
  localparam int CW = 3;
  localparam int NSTEP = 11;
  // {kick, rx, glitch, pin_direct, tx, fifo, uart, sync}
  localparam logic [7:0] STEPS [NSTEP] = '{
    8'b0_0_0_10000, // R1/R5 first tick after reset never accepted
    8'b0_0_0_11000, // R6 held low -> master high
    8'b0_1_0_11000, // R5 change in interval voids it
    8'b0_1_0_01111, // R7/R9 held high -> done
    8'b1_1_0_10100, // R2 break entry
    8'b0_1_0_10000, // R3 flush at first tick
    8'b0_0_0_10000, // R4 one step
    8'b0_0_1_10000, // R5 glitch voids interval
    8'b0_0_0_11000, // R6
    8'b0_1_0_11000, // R5
    8'b0_1_0_01111  // R7/R9
  };

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, is_master = 1'b1;
  logic brk_det = 1'b0, err_req = 1'b0, rx_lvl = 1'b0;
  logic pin_direct, tx_lvl, uart_en, fifo_en, dma_stop, sync_done;
  logic [CW-1:0] resync_cnt;
  int n_chk = 0, n_bad = 0, exp_cnt = 0;
  bit ended = 0;

  always #(CLK_P/2) clk = ~clk;

  link_resync_ctrl #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .tick(tick), .is_master(is_master),
    .brk_det(brk_det), .err_req(err_req), .rx_lvl(rx_lvl),
    .pin_direct(pin_direct), .tx_lvl(tx_lvl), .uart_en(uart_en),
    .fifo_en(fifo_en), .dma_stop(dma_stop), .sync_done(sync_done),
    .resync_cnt(resync_cnt)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_pins(string tag, logic pd, logic tx, logic f, logic u, logic sd);
    chk({tag, " pin_direct"}, pin_direct, pd);
    chk({tag, " tx_lvl"}, tx_lvl, tx);
    chk({tag, " fifo_en"}, fifo_en, f);
    chk({tag, " uart_en"}, uart_en, u);
    chk({tag, " dma_stop"}, dma_stop, pd);
    chk({tag, " sync_done"}, sync_done, sd);
    chk({tag, " resync_cnt"}, resync_cnt, exp_cnt);
  endtask

  task automatic interval(logic lvl, logic glitch);
    rx_lvl = lvl;
    repeat (2) @(negedge clk);
    if (glitch) begin
      rx_lvl = ~lvl;
      @(negedge clk);
      rx_lvl = lvl;
    end
    repeat (2) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic kick(logic use_err);
    if (use_err) err_req = 1'b1; else brk_det = 1'b1;
    @(negedge clk);
    brk_det = 1'b0;
    err_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_pins("R1 reset", 1, 0, 0, 0, 0);

    for (int i = 0; i < NSTEP; i++) begin
      if (STEPS[i][7]) begin
        rx_lvl = STEPS[i][6];
        kick(1'b0);
      end else begin
        interval(STEPS[i][6], STEPS[i][5]);
      end
      if (STEPS[i][0]) exp_cnt = (exp_cnt == 7) ? 7 : exp_cnt + 1;
      chk_pins($sformatf("R4 table step %0d", i), STEPS[i][4], STEPS[i][3],
               STEPS[i][2], STEPS[i][1], STEPS[i][0]);
      if (STEPS[i][0]) begin
        @(negedge clk);
        chk("R9 sync pulse one cycle", sync_done, 0);
      end
    end

    // R11 tick while running
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
    chk_pins("R11 tick in run", 0, 1, 1, 1, 0);

    // R2 entry through error request
    kick(1'b1);
    chk_pins("R2 err entry", 1, 0, 1, 0, 0);
    // R10 request during recovery ignored, R3 fifo held until tick
    brk_det = 1'b1;
    repeat (3) @(negedge clk);
    brk_det = 1'b0;
    chk_pins("R10 R3 no tick", 1, 0, 1, 0, 0);
    interval(1'b1, 1'b0);
    chk_pins("R3 flush", 1, 0, 0, 0, 0);

    // R8 responder
    is_master = 1'b0;
    interval(1'b1, 1'b0);
    chk_pins("R8 to wait", 1, 0, 0, 0, 0);
    interval(1'b1, 1'b0);
    chk_pins("R8 high before low ignored", 1, 0, 0, 0, 0);
    interval(1'b0, 1'b0);
    chk_pins("R5 change voids", 1, 0, 0, 0, 0);
    interval(1'b0, 1'b0);
    chk_pins("R8 low seen tx stays low", 1, 0, 0, 0, 0);
    interval(1'b1, 1'b0);
    chk_pins("R8 high voided", 1, 0, 0, 0, 0);
    // R10 break coincides with completing tick
    rx_lvl = 1'b1;
    repeat (4) @(negedge clk);
    tick = 1'b1;
    brk_det = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    exp_cnt++;
    chk_pins("R10 completion wins", 0, 1, 1, 1, 1);
    @(negedge clk);
    brk_det = 1'b0;
    chk_pins("R10 restart next cycle", 1, 0, 1, 0, 0);

    // R9 saturation, master role
    is_master = 1'b1;
    for (int k = 0; k < 5; k++) begin
      interval(1'b1, 1'b0);
      interval(1'b0, 1'b0);
      interval(1'b0, 1'b0);
      chk("R6 master high", tx_lvl, 1);
      interval(1'b1, 1'b0);
      interval(1'b1, 1'b0);
      exp_cnt = (exp_cnt == 7) ? 7 : exp_cnt + 1;
      chk_pins($sformatf("R9 saturate round %0d", k), 0, 1, 1, 1, 1);
      if (k < 4) kick(1'b0);
    end
    chk("R9 count at max", resync_cnt, 7);

    ended = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!ended) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule